// File: doc/BRIEF.md
# Cascadable Output Serializer

This block turns parallel words that arrive on a slow divided clock into a serial bit stream on a fast clock. It has two converters that share one clock pair. The data converter sends words of 2 to 6 bits. The output-enable converter sends 1, 2 or 4 enable bits per word. The ratio of the fast clock to the divided clock equals the data width, so each divided-clock period carries exactly one word, and no bit is dropped or repeated.

Two instances can be chained to reach 7 to 10 data bits. The master holds the first six bits. The slave holds the rest and feeds them to the master through two carry lines: one carries data and one carries output-enable bits. The stream is paced by the divided clock. No valid/ready handshake exists: one word is taken on every rising edge of the divided clock, and no back-pressure exists. The two clock enables are the only way to pause a path.

Top module: `par2ser_out`

## Requirements
- R1: The bits leave the data output least significant first. Input bit 0 appears first, then bit 1, and so on, one bit per fast-clock cycle.
- R2: In standalone mode (`cfg_mode` = 2'b00), `cfg_width` selects 2 to 6 bits. With the divided clock at the fast clock divided by that width, consecutive words form an unbroken stream with no missing or repeated bit.
- R3: In cascade, the master has `cfg_mode` = 2'b01 and the slave has `cfg_mode` = 2'b10. The slave's `cfg_width` equals the total width minus 6, which is 1 to 4. The slave's `shift_out_data` drives the master's `shift_in_data`. The master's output is then master bits 0..5 followed by slave bits 0 upward, for 7 to 10 bits in total.
- R4: A word captured on a rising edge of `divclk` puts its bit 0 on `ser_data` and `ser_tri` after the second rising edge of `clk` that follows. This latency is the same for every word.
- R5: `cfg_tri_width` selects the enable width: 2'b00 gives 1 bit, 2'b01 gives 2 bits and 2'b10 gives 4 bits. `ser_tri` sends `par_tri` bits 0 upward. When the enable width is less than 4, the last selected bit fills the remaining register positions up to position 3. Once the register is exhausted, the last bit holds until the next word.
- R6: In cascade, the slave's `shift_out_tri` drives the master's `shift_in_tri`. The master's `ser_tri` sends the master's four enable positions and then the slave's four. The slave's last position then repeats.
- R7: While `rst` is high, every rising edge of `clk` leaves `ser_data` at 0 and `ser_tri` at 1 (driver disabled).
- R8: While `data_ce` is low, `ser_data` and the data shift state hold, and no new data word is captured. While `tri_ce` is low, the same holds for `ser_tri` and the enable path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| divclk | input | 1 | Divided clock; one word is taken on each rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | 00 standalone, 01 cascade master, 10 cascade slave |
| cfg_width | input | 3 | Data bits per word in standalone or slave mode |
| cfg_tri_width | input | 2 | Enable width: 00 gives 1, 01 gives 2, 10 gives 4 |
| data_ce | input | 1 | Data path clock enable, active high |
| tri_ce | input | 1 | Enable path clock enable, active high |
| par_data | input | 6 | Parallel data word |
| par_tri | input | 4 | Parallel output-enable bits (1 = disabled) |
| shift_in_data | input | 1 | Data carry from the slave (master only) |
| shift_in_tri | input | 1 | Enable carry from the slave (master only) |
| ser_data | output | 1 | Serial data |
| ser_tri | output | 1 | Serial output-enable (1 = high impedance) |
| shift_out_data | output | 1 | Data carry toward the master |
| shift_out_tri | output | 1 | Enable carry toward the master |

## Verification
A load pulse that fires one fast cycle early or late shifts every later word by a bit position. Because the scoreboard expects bit 0 exactly two fast edges after each capture, the fault shows at the first wrong bit of the first word. A fault in the fill logic (zero fill or last-bit fill) or in the carry selection first shows in the tail of a word: in the bits past position 3 of the enable stream, or past bit 5 of the data stream in cascade. A frozen or leaking clock enable shows within one cycle as a change during the hold window.

// File: rtl/p2s_pkg.sv
`timescale 1ns/1ps
package p2s_pkg;
  typedef enum logic [1:0] {
    MODE_SOLO   = 2'b00,
    MODE_MASTER = 2'b01,
    MODE_SLAVE  = 2'b10
  } p2s_mode_e;

  // number of enable bits selected by the 2-bit width code
  function automatic int tri_count(input logic [1:0] code, input int max_bits);
    case (code)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return max_bits;
    endcase
  endfunction
endpackage

// File: rtl/p2s_capture.sv
`timescale 1ns/1ps
// Divided-clock side: holds the parallel words and flags each capture by toggling.
module p2s_capture #(
  parameter int DW = 6,
  parameter int TW = 4
) (
  input  logic          divclk,
  input  logic          rst,
  input  logic          data_ce,
  input  logic          tri_ce,
  input  logic [DW-1:0] par_data,
  input  logic [TW-1:0] par_tri,
  output logic [DW-1:0] hold_data,
  output logic [TW-1:0] hold_tri,
  output logic          flip
);
  always_ff @(posedge divclk) begin
    if (rst) begin
      hold_data <= '0;
      hold_tri  <= '1;
      flip      <= 1'b0;
    end else begin
      flip <= ~flip;
      if (data_ce) hold_data <= par_data;
      if (tri_ce)  hold_tri  <= par_tri;
    end
  end

  // R8: a disabled data path captures nothing new
  p_capture_hold_r8: assert property (@(posedge divclk) disable iff (rst)
    !data_ce |=> $stable(hold_data));
endmodule

// File: rtl/p2s_loadgen.sv
`timescale 1ns/1ps
// Fast-clock side: turns each capture toggle into a single-cycle load pulse.
module p2s_loadgen (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  output logic load
);
  logic seen1, seen2;

  always_ff @(posedge clk) begin
    seen1 <= flip;
    seen2 <= seen1;
  end

  assign load = (seen1 ^ seen2) & ~rst;

  // R4: with a ratio of at least two, loads never come back to back
  p_load_gap_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);
endmodule

// File: rtl/p2s_shiftreg.sv
`timescale 1ns/1ps
// Load-or-shift register, bit 0 leaves first. The fill source is chosen by parameter.
module p2s_shiftreg #(
  parameter int             LEN       = 6,
  parameter bit             FILL_LAST = 1'b0,
  parameter logic [LEN-1:0] RST_VAL   = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           load,
  input  logic [LEN-1:0] load_val,
  input  logic           use_ext,
  input  logic           ext_in,
  output logic           lsb
);
  logic [LEN-1:0] q;
  logic           fill;

  generate
    if (FILL_LAST) begin : g_fill_last
      assign fill = use_ext ? ext_in : q[LEN-1];
    end else begin : g_fill_zero
      assign fill = use_ext ? ext_in : 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       q <= RST_VAL;
    else if (en)   q <= load ? load_val : {fill, q[LEN-1:1]};
  end

  assign lsb = q[0];

  // R8: a disabled path keeps its whole shift state
  p_hold_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
endmodule

// File: rtl/par2ser_out.sv
`timescale 1ns/1ps
module par2ser_out #(
  parameter int DW = 6,
  parameter int TW = 4,
  localparam int WW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          divclk,
  input  logic          rst,
  input  logic [1:0]    cfg_mode,
  input  logic [WW-1:0] cfg_width,
  input  logic [1:0]    cfg_tri_width,
  input  logic          data_ce,
  input  logic          tri_ce,
  input  logic [DW-1:0] par_data,
  input  logic [TW-1:0] par_tri,
  input  logic          shift_in_data,
  input  logic          shift_in_tri,
  output logic          ser_data,
  output logic          ser_tri,
  output logic          shift_out_data,
  output logic          shift_out_tri
);
  import p2s_pkg::*;

  logic [DW-1:0] hold_data, data_mask, data_load;
  logic [TW-1:0] hold_tri, tri_mask, tri_load;
  logic          flip, load, is_master, tri_last;
  int            tri_n;

  assign is_master = (cfg_mode == MODE_MASTER);

  p2s_capture #(.DW(DW), .TW(TW)) u_cap (
    .divclk(divclk), .rst(rst), .data_ce(data_ce), .tri_ce(tri_ce),
    .par_data(par_data), .par_tri(par_tri),
    .hold_data(hold_data), .hold_tri(hold_tri), .flip(flip));

  p2s_loadgen u_ld (.clk(clk), .rst(rst), .flip(flip), .load(load));

  // master sends all DW bits; standalone and slave keep only the selected width
  always_comb begin
    for (int i = 0; i < DW; i++)
      data_mask[i] = is_master || (i < {{(32-WW){1'b0}}, cfg_width});
    data_load = hold_data & data_mask;
  end

  // enable bits above the selected width repeat the last selected bit
  always_comb begin
    tri_n = tri_count(cfg_tri_width, TW);
    for (int i = 0; i < TW; i++) tri_mask[i] = (i < tri_n);
    case (cfg_tri_width)
      2'b00:   tri_last = hold_tri[0];
      2'b01:   tri_last = hold_tri[1];
      default: tri_last = hold_tri[TW-1];
    endcase
    tri_load = (hold_tri & tri_mask) | ({TW{tri_last}} & ~tri_mask);
  end

  p2s_shiftreg #(.LEN(DW), .FILL_LAST(1'b0), .RST_VAL('0)) u_data_sr (
    .clk(clk), .rst(rst), .en(data_ce), .load(load), .load_val(data_load),
    .use_ext(is_master), .ext_in(shift_in_data), .lsb(ser_data));

  p2s_shiftreg #(.LEN(TW), .FILL_LAST(1'b1), .RST_VAL('1)) u_tri_sr (
    .clk(clk), .rst(rst), .en(tri_ce), .load(load), .load_val(tri_load),
    .use_ext(is_master), .ext_in(shift_in_tri), .lsb(ser_tri));

  assign shift_out_data = ser_data;
  assign shift_out_tri  = ser_tri;

  // R7: reset drives the data line low and disables the driver
  p_reset_idle_r7: assert property (@(posedge clk)
    rst |=> (ser_data == 1'b0 && ser_tri == 1'b1));

  // R5: a standalone one-bit enable word holds steady between loads
  p_tri_single_steady_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == MODE_SOLO && cfg_tri_width == 2'b00 && !load) |=> $stable(ser_tri));
endmodule

// File: tb/tb_par2ser_out.sv
`timescale 1ns/1ps
module tb_par2ser_out;
  logic       clk = 1'b0, divclk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'b00, twc = 2'b00;
  logic [2:0] m_width = 3'd2, s_width = 3'd1;
  logic       data_ce = 1'b1, tri_ce = 1'b1;
  logic [5:0] dm = '0, ds = '0;
  logic [3:0] tm = '0, ts = '0;
  logic       ser_data, ser_tri, m_sod, m_sot;
  logic       s_ser_data, s_ser_tri, s_sod, s_sot;

  int ratio = 2, div_cnt = 0, cyc = 0;
  int errors = 0, checks = 0, mon_start = 0;
  bit mon_on = 1'b0, casc_now = 1'b0;
  bit exp_oq[$], exp_tq[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (div_cnt >= ratio - 1) div_cnt <= 0; else div_cnt <= div_cnt + 1;
    divclk <= (div_cnt == ratio - 1);
  end

  par2ser_out dut (
    .clk(clk), .divclk(divclk), .rst(rst), .cfg_mode(mode), .cfg_width(m_width),
    .cfg_tri_width(twc), .data_ce(data_ce), .tri_ce(tri_ce), .par_data(dm), .par_tri(tm),
    .shift_in_data(s_sod), .shift_in_tri(s_sot), .ser_data(ser_data), .ser_tri(ser_tri),
    .shift_out_data(m_sod), .shift_out_tri(m_sot));

  par2ser_out slv (
    .clk(clk), .divclk(divclk), .rst(rst), .cfg_mode(2'b10), .cfg_width(s_width),
    .cfg_tri_width(twc), .data_ce(data_ce), .tri_ce(tri_ce), .par_data(ds), .par_tri(ts),
    .shift_in_data(1'b0), .shift_in_tri(1'b0), .ser_data(s_ser_data), .ser_tri(s_ser_tri),
    .shift_out_data(s_sod), .shift_out_tri(s_sot));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic tri_at(input logic [3:0] v, input int n, input int pos);
    return v[(pos < n) ? pos : n - 1];
  endfunction

  // monitor: bit 0 of each word is due two fast edges after its capture (R4)
  always @(negedge clk) begin
    bit eo, et;
    if (mon_on && cyc >= mon_start && exp_oq.size() > 0) begin
      eo = exp_oq.pop_front();
      et = exp_tq.pop_front();
      if (casc_now) begin
        chk("R3/R4 cascade data", ser_data, eo);
        chk("R6 cascade enable", ser_tri, et);
      end else begin
        chk("R1/R2/R4 data", ser_data, eo);
        chk("R5 enable", ser_tri, et);
      end
    end
  end

  task automatic run_phase(input int r, input bit casc, input logic [1:0] tw_code, input int nwords);
    int  twn;
    logic held;
    twn = (tw_code == 2'b00) ? 1 : (tw_code == 2'b01) ? 2 : 4;
    @(negedge clk);
    rst = 1'b1; mon_on = 1'b0; casc_now = casc; ratio = r;
    mode = casc ? 2'b01 : 2'b00;
    m_width = casc ? 3'd6 : 3'(r);
    s_width = casc ? 3'(r - 6) : 3'd1;
    twc = tw_code; data_ce = 1'b1; tri_ce = 1'b1;
    exp_oq.delete(); exp_tq.delete();
    repeat (2 * r + 4) @(negedge clk);
    chk("R7 reset data low", ser_data, 1'b0);
    chk("R7 reset driver off", ser_tri, 1'b1);
    rst = 1'b0;
    for (int w = 0; w < nwords; w++) begin
      do @(negedge clk); while (div_cnt != r - 1);
      dm = 6'($urandom); ds = 6'($urandom); tm = 4'($urandom); ts = 4'($urandom);
      if (w == 0) begin mon_start = cyc + 3; mon_on = 1'b1; end
      for (int c = 0; c < r; c++) begin
        logic eo, et;
        if (!casc || c < 6) eo = dm[c]; else eo = ds[c - 6];
        if (!casc)      et = tri_at(tm, twn, (c > 3) ? 3 : c);
        else if (c < 4) et = tri_at(tm, twn, c);
        else            et = tri_at(ts, twn, (c - 4 > 3) ? 3 : c - 4);
        exp_oq.push_back(eo);
        exp_tq.push_back(et);
      end
    end
    while (exp_oq.size() > 0) @(negedge clk);
    mon_on = 1'b0;
    // R8: data path frozen while its enable is low
    @(negedge clk);
    data_ce = 1'b0; held = ser_data;
    repeat (8) begin @(negedge clk); chk("R8 data hold", ser_data, held); end
    data_ce = 1'b1;
    // R8: enable path frozen while its enable is low
    @(negedge clk);
    tri_ce = 1'b0; held = ser_tri;
    repeat (8) begin @(negedge clk); chk("R8 enable hold", ser_tri, held); end
    tri_ce = 1'b1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog (R1): actual still running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    run_phase(2, 1'b0, 2'b00, 12);  // R2 narrowest, R5 one bit
    run_phase(3, 1'b0, 2'b01, 12);  // R5 two bits
    run_phase(4, 1'b0, 2'b10, 12);  // R5 four bits
    run_phase(5, 1'b0, 2'b00, 12);
    run_phase(6, 1'b0, 2'b10, 12);  // R2 widest standalone
    run_phase(7, 1'b1, 2'b10, 12);  // R3 R6 cascade
    run_phase(8, 1'b1, 2'b10, 12);
    run_phase(9, 1'b1, 2'b01, 12);
    run_phase(10, 1'b1, 2'b10, 12);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule